// File: doc/BRIEF.md
# Limited-Pointer Sharer Tracker for One Directory Entry

This block keeps the sharer record of a single coherence directory entry. Instead of one presence bit per node, it holds a small fixed set of node identifiers, each `$clog2(NODES)` bits wide. For example, 1024 nodes need 10-bit identifiers. A few sharers fill the common case exactly. When one more sharer arrives than the set can hold, a run-time selectable overflow policy decides what happens:
- **Broadcast:** the entry gives up precise tracking.
- **Replace:** an existing sharer is displaced and must be invalidated.
- **Coarse:** the entry is folded into one bit per cluster of `CLUSTER` consecutive nodes.

A home controller feeds one command per cycle: add a sharer, remove a sharer, or a write by some node. One cycle after a write, or after a replacement, the block presents the set of nodes to invalidate as a node mask. When precision has been lost entirely, it raises a broadcast flag instead. The `sharer_mask` output always shows the node set the entry currently stands for. Message transport and data movement belong to the surrounding controller.

Top module: `lptr_dir_entry`

## Requirements
- R1: While `rst_n` is low, and after its release with no command given, `sharer_mask`, `inv_mask`, `inv_valid` and `inv_all` are all zero, and the entry is in pointer mode with no pointers used.
- R2: `cmd_op` = 1 adds `cmd_node`. In pointer mode with a free slot, the node takes the lowest free slot, and `sharer_mask` shows bit `cmd_node` set after the next rising edge.
- R3: Adding a node the entry already covers changes neither `sharer_mask` nor the invalidation outputs.
- R4: `cmd_op` = 2 removes `cmd_node`.
  - In pointer mode this clears the matching pointer.
  - Removing a node that is not recorded has no effect.
  - In broadcast or coarse mode the command is ignored.
- R5: `cmd_op` = 3 is a write by `cmd_node`. One cycle later `inv_valid` is 1 and `inv_mask` equals the previous `sharer_mask` with the writer's bit cleared. The entry then returns to pointer mode holding only the writer in slot 0, and the replacement index returns to slot 0.
- R6: `ovf_policy` 0 or 3 selects broadcast. Adding a new node to a full pointer set makes `sharer_mask` all ones. The next write sets `inv_all` together with `inv_valid`.
- R7: `ovf_policy` 1 selects replace. Adding a new node to a full pointer set overwrites the slot at a round-robin index. The index starts at slot 0 after reset or a write and advances by one per replacement, wrapping after the last slot. One cycle later `inv_valid` is 1 and `inv_mask` has exactly the displaced node's bit set.
- R8: `ovf_policy` 2 selects coarse. Adding a new node to a full pointer set switches the entry to a cluster vector, where bit c covers nodes c*CLUSTER to c*CLUSTER+CLUSTER-1.
  - At the switch, the vector marks the clusters of all recorded nodes and of the new node.
  - Later adds mark their node's cluster.
  - `sharer_mask` shows every node of each marked cluster, and a write invalidates all of them except the writer.
- R9: `inv_valid` is high only in the cycle after a write or a replacement. `inv_all` is never high without `inv_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ovf_policy | input | 2 | Overflow policy: 0/3 broadcast, 1 replace, 2 coarse |
| cmd_op | input | 2 | 0 none, 1 add sharer, 2 remove sharer, 3 write |
| cmd_node | input | $clog2(NODES) | Node the command refers to |
| sharer_mask | output | NODES | Node set the entry currently represents |
| inv_valid | output | 1 | Invalidation set presented this cycle |
| inv_all | output | 1 | Invalidate every node (broadcast) |
| inv_mask | output | NODES | Nodes to invalidate |

## Verification
The add path is driven under all four policy codes up to and past a full pointer set, with each policy answering the same overflow differently:
- Broadcast produces an all-ones set, and a write must then raise the broadcast flag.
- Replace produces single-node invalidations. Here the displaced node identity reveals whether the round-robin index starts, advances and wraps correctly, and whether a write resets it.
- Coarse produces cluster-granular masks, which separate a correct node-to-cluster fold from an off-by-one cluster boundary.

Duplicate adds, removals of absent nodes and removals in the imprecise modes are interleaved so that a design that alters state on such commands shows a changed `sharer_mask`.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ADD   = 2'd1,
    OP_REM   = 2'd2,
    OP_WRITE = 2'd3
  } dlp_op_e;

  typedef enum logic [1:0] {
    MODE_PTR    = 2'd0,
    MODE_BCAST  = 2'd1,
    MODE_COARSE = 2'd2
  } dlp_mode_e;

  localparam logic [1:0] POL_BCAST   = 2'd0;
  localparam logic [1:0] POL_REPLACE = 2'd1;
  localparam logic [1:0] POL_COARSE  = 2'd2;
endpackage

// File: rtl/dlp_ptr_scan.sv
// Compares a node id against every pointer slot, finds the lowest free
// slot and expands the valid pointers into a node mask.
module dlp_ptr_scan #(
  parameter int NODES = 16,
  parameter int PTRS  = 3,
  localparam int ID_W  = $clog2(NODES),
  localparam int IDX_W = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic [PTRS-1:0][ID_W-1:0] ptr_id,
  input  logic [PTRS-1:0]           ptr_vld,
  input  logic [ID_W-1:0]           node,
  output logic [PTRS-1:0]           hit_vec,
  output logic                      free_any,
  output logic [IDX_W-1:0]          free_idx,
  output logic [NODES-1:0]          ptr_mask
);
  for (genvar s = 0; s < PTRS; s++) begin : g_slot
    assign hit_vec[s] = ptr_vld[s] && (ptr_id[s] == node);
  end

  assign free_any = ~&ptr_vld;

  always_comb begin
    free_idx = '0;
    for (int i = PTRS - 1; i >= 0; i--) begin
      if (!ptr_vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    ptr_mask = '0;
    for (int i = 0; i < PTRS; i++) begin
      if (ptr_vld[i]) ptr_mask = ptr_mask | (NODES'(1) << ptr_id[i]);
    end
  end
endmodule

// File: rtl/dlp_cluster_map.sv
// Folds a node mask into a cluster vector and expands a cluster vector
// back into the nodes it covers.
module dlp_cluster_map #(
  parameter int NODES   = 16,
  parameter int CLUSTER = 4,
  localparam int NCLUS  = NODES / CLUSTER
) (
  input  logic [NCLUS-1:0] clus_vec,
  input  logic [NODES-1:0] in_mask,
  output logic [NODES-1:0] exp_mask,
  output logic [NCLUS-1:0] fold_vec
);
  for (genvar c = 0; c < NCLUS; c++) begin : g_clus
    assign exp_mask[c*CLUSTER +: CLUSTER] = {CLUSTER{clus_vec[c]}};
    assign fold_vec[c] = |in_mask[c*CLUSTER +: CLUSTER];
  end
endmodule

// File: rtl/lptr_dir_entry.sv
module lptr_dir_entry
  import dlp_pkg::*;
#(
  parameter int NODES   = 16,
  parameter int PTRS    = 3,
  parameter int CLUSTER = 4,
  localparam int ID_W   = $clog2(NODES),
  localparam int IDX_W  = (PTRS > 1) ? $clog2(PTRS) : 1,
  localparam int NCLUS  = NODES / CLUSTER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ovf_policy,
  input  logic [1:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_node,
  output logic [NODES-1:0] sharer_mask,
  output logic             inv_valid,
  output logic             inv_all,
  output logic [NODES-1:0] inv_mask
);
  // entry state
  logic [PTRS-1:0][ID_W-1:0] ptr_id_q,  ptr_id_d;
  logic [PTRS-1:0]           ptr_vld_q, ptr_vld_d;
  dlp_mode_e                 mode_q,    mode_d;
  logic [NCLUS-1:0]          clus_q,    clus_d;
  logic [IDX_W-1:0]          rr_q,      rr_d;
  // invalidation outputs
  logic                      inv_valid_q, inv_valid_d;
  logic                      inv_all_q,   inv_all_d;
  logic [NODES-1:0]          inv_mask_q,  inv_mask_d;

  logic [PTRS-1:0]  hit_vec;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [NODES-1:0] ptr_mask, exp_mask, node_oh, cur_mask;
  logic [NCLUS-1:0] fold_vec;
  logic             st_en;
  dlp_op_e          op;

  assign op      = dlp_op_e'(cmd_op);
  assign node_oh = NODES'(1) << cmd_node;
  assign st_en   = (op != OP_NONE);

  dlp_ptr_scan #(.NODES(NODES), .PTRS(PTRS)) u_scan (
    .ptr_id   (ptr_id_q),
    .ptr_vld  (ptr_vld_q),
    .node     (cmd_node),
    .hit_vec  (hit_vec),
    .free_any (free_any),
    .free_idx (free_idx),
    .ptr_mask (ptr_mask)
  );

  // pointers are cleared outside pointer mode, so the fold carries only
  // the new node's cluster there
  dlp_cluster_map #(.NODES(NODES), .CLUSTER(CLUSTER)) u_clus (
    .clus_vec (clus_q),
    .in_mask  (ptr_mask | node_oh),
    .exp_mask (exp_mask),
    .fold_vec (fold_vec)
  );

  always_comb begin
    case (mode_q)
      MODE_BCAST:  cur_mask = '1;
      MODE_COARSE: cur_mask = exp_mask;
      default:     cur_mask = ptr_mask;
    endcase
  end

  // next-state process
  always_comb begin
    ptr_id_d    = ptr_id_q;
    ptr_vld_d   = ptr_vld_q;
    mode_d      = mode_q;
    clus_d      = clus_q;
    rr_d        = rr_q;
    inv_valid_d = 1'b0;
    inv_all_d   = 1'b0;
    inv_mask_d  = '0;
    case (op)
      OP_ADD: begin
        if (mode_q == MODE_COARSE) begin
          clus_d = clus_q | fold_vec;
        end else if (mode_q == MODE_PTR && !(|hit_vec)) begin
          if (free_any) begin
            ptr_id_d[free_idx]  = cmd_node;
            ptr_vld_d[free_idx] = 1'b1;
          end else if (ovf_policy == POL_REPLACE) begin
            inv_valid_d      = 1'b1;
            inv_mask_d       = NODES'(1) << ptr_id_q[rr_q];
            ptr_id_d[rr_q]   = cmd_node;
            rr_d             = (rr_q == IDX_W'(PTRS - 1)) ? '0 : rr_q + 1'b1;
          end else if (ovf_policy == POL_COARSE) begin
            mode_d    = MODE_COARSE;
            clus_d    = fold_vec;
            ptr_vld_d = '0;
          end else begin
            mode_d    = MODE_BCAST;
            ptr_vld_d = '0;
          end
        end
      end
      OP_REM: begin
        if (mode_q == MODE_PTR) ptr_vld_d = ptr_vld_q & ~hit_vec;
      end
      OP_WRITE: begin
        inv_valid_d = 1'b1;
        inv_all_d   = (mode_q == MODE_BCAST);
        inv_mask_d  = cur_mask & ~node_oh;
        mode_d      = MODE_PTR;
        clus_d      = '0;
        rr_d        = '0;
        ptr_vld_d   = PTRS'(1);
        ptr_id_d[0] = cmd_node;
      end
      default: ;
    endcase
  end

  // register process: entry state, clock-enabled by a command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_id_q  <= '0;
      ptr_vld_q <= '0;
      mode_q    <= MODE_PTR;
      clus_q    <= '0;
      rr_q      <= '0;
    end else if (st_en) begin
      ptr_id_q  <= ptr_id_d;
      ptr_vld_q <= ptr_vld_d;
      mode_q    <= mode_d;
      clus_q    <= clus_d;
      rr_q      <= rr_d;
    end
  end

  // register process: invalidation outputs, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_valid_q <= 1'b0;
      inv_all_q   <= 1'b0;
      inv_mask_q  <= '0;
    end else begin
      inv_valid_q <= inv_valid_d;
      inv_all_q   <= inv_all_d;
      inv_mask_q  <= inv_mask_d;
    end
  end

  assign sharer_mask = cur_mask;
  assign inv_valid   = inv_valid_q;
  assign inv_all     = inv_all_q;
  assign inv_mask    = inv_mask_q;

  // R2
  add_covers_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1) |=> sharer_mask[$past(cmd_node)]);

  // R5
  wr_leaves_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3) |=> (sharer_mask == (NODES'(1) << $past(cmd_node))));

  // R5
  wr_spares_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3) |=> (inv_valid && !inv_mask[$past(cmd_node)]));

  // R7
  replace_single_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && ($past(cmd_op) != 2'd3)) |-> ($countones(inv_mask) == 1));

  // R9
  all_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> inv_valid);

  // R9
  quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd0) |=> !inv_valid);
endmodule

// File: tb/lptr_dir_entry_test.sv
`timescale 1ns/1ps
module lptr_dir_entry_test;
  localparam int NODES = 16;
  localparam int PTRS  = 3;
  localparam int CLUS  = 4;
  localparam int NV    = 29;

  logic        clk;
  logic        rst_n;
  logic [1:0]  ovf_policy;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_node;
  logic [15:0] sharer_mask;
  logic        inv_valid;
  logic        inv_all;
  logic [15:0] inv_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lptr_dir_entry #(.NODES(NODES), .PTRS(PTRS), .CLUSTER(CLUS)) uut (
    .clk(clk), .rst_n(rst_n), .ovf_policy(ovf_policy), .cmd_op(cmd_op),
    .cmd_node(cmd_node), .sharer_mask(sharer_mask), .inv_valid(inv_valid),
    .inv_all(inv_all), .inv_mask(inv_mask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req[45:42], policy[41:40], op[39:38], node[37:34],
  //  exp_valid[33], exp_all[32], exp_inv[31:16], exp_sharers[15:0]}
  localparam logic [45:0] VEC [NV] = '{
    {4'd2, 2'd0, 2'd1, 4'd2,  1'b0, 1'b0, 16'h0000, 16'h0004},
    {4'd2, 2'd0, 2'd1, 4'd5,  1'b0, 1'b0, 16'h0000, 16'h0024},
    {4'd3, 2'd0, 2'd1, 4'd2,  1'b0, 1'b0, 16'h0000, 16'h0024},
    {4'd2, 2'd0, 2'd1, 4'd9,  1'b0, 1'b0, 16'h0000, 16'h0224},
    {4'd4, 2'd0, 2'd2, 4'd5,  1'b0, 1'b0, 16'h0000, 16'h0204},
    {4'd2, 2'd0, 2'd1, 4'd11, 1'b0, 1'b0, 16'h0000, 16'h0A04},
    {4'd6, 2'd0, 2'd1, 4'd14, 1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {4'd4, 2'd0, 2'd2, 4'd2,  1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {4'd6, 2'd0, 2'd3, 4'd7,  1'b1, 1'b1, 16'hFF7F, 16'h0080},
    {4'd3, 2'd0, 2'd1, 4'd7,  1'b0, 1'b0, 16'h0000, 16'h0080},
    {4'd2, 2'd1, 2'd1, 4'd1,  1'b0, 1'b0, 16'h0000, 16'h0082},
    {4'd2, 2'd1, 2'd1, 4'd3,  1'b0, 1'b0, 16'h0000, 16'h008A},
    {4'd7, 2'd1, 2'd1, 4'd12, 1'b1, 1'b0, 16'h0080, 16'h100A},
    {4'd7, 2'd1, 2'd1, 4'd13, 1'b1, 1'b0, 16'h0002, 16'h3008},
    {4'd3, 2'd1, 2'd1, 4'd3,  1'b0, 1'b0, 16'h0000, 16'h3008},
    {4'd7, 2'd1, 2'd1, 4'd0,  1'b1, 1'b0, 16'h0008, 16'h3001},
    {4'd7, 2'd1, 2'd1, 4'd6,  1'b1, 1'b0, 16'h1000, 16'h2041},
    {4'd5, 2'd1, 2'd3, 4'd13, 1'b1, 1'b0, 16'h0041, 16'h2000},
    {4'd2, 2'd2, 2'd1, 4'd4,  1'b0, 1'b0, 16'h0000, 16'h2010},
    {4'd2, 2'd2, 2'd1, 4'd5,  1'b0, 1'b0, 16'h0000, 16'h2030},
    {4'd8, 2'd2, 2'd1, 4'd0,  1'b0, 1'b0, 16'h0000, 16'hF0FF},
    {4'd3, 2'd2, 2'd1, 4'd4,  1'b0, 1'b0, 16'h0000, 16'hF0FF},
    {4'd4, 2'd2, 2'd2, 4'd13, 1'b0, 1'b0, 16'h0000, 16'hF0FF},
    {4'd8, 2'd2, 2'd3, 4'd1,  1'b1, 1'b0, 16'hF0FD, 16'h0002},
    {4'd9, 2'd2, 2'd0, 4'd0,  1'b0, 1'b0, 16'h0000, 16'h0002},
    {4'd2, 2'd3, 2'd1, 4'd2,  1'b0, 1'b0, 16'h0000, 16'h0006},
    {4'd2, 2'd3, 2'd1, 4'd8,  1'b0, 1'b0, 16'h0000, 16'h0106},
    {4'd6, 2'd3, 2'd1, 4'd15, 1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {4'd6, 2'd3, 2'd3, 4'd15, 1'b1, 1'b1, 16'h7FFF, 16'h8000}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] pol, input logic [1:0] op,
                       input logic [3:0] node);
    @(negedge clk);
    ovf_policy = pol;
    cmd_op     = op;
    cmd_node   = node;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 10000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ovf_policy = 2'd0; cmd_op = 2'd0; cmd_node = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", "sharers in reset", sharer_mask, 16'h0000);
    check("R1", "inv_valid in reset", {15'd0, inv_valid}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    issue(2'd0, 2'd0, 4'd0);
    // R1 after release
    check("R1", "sharers after release", sharer_mask, 16'h0000);
    check("R1", "inv_mask after release", inv_mask, 16'h0000);
    check("R1", "inv_all after release", {15'd0, inv_all}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][41:40], VEC[i][39:38], VEC[i][37:34]);
      check(rtag(VEC[i][45:42]), $sformatf("step %0d inv_valid", i),
            {15'd0, inv_valid}, {15'd0, VEC[i][33]});
      check(rtag(VEC[i][45:42]), $sformatf("step %0d inv_all", i),
            {15'd0, inv_all}, {15'd0, VEC[i][32]});
      check(rtag(VEC[i][45:42]), $sformatf("step %0d inv_mask", i),
            inv_mask, VEC[i][31:16]);
      check(rtag(VEC[i][45:42]), $sformatf("step %0d sharers", i),
            sharer_mask, VEC[i][15:0]);
    end

    // R4 remove of absent node in pointer mode, then a real removal
    issue(2'd0, 2'd1, 4'd4);
    check("R4", "add before remove", sharer_mask, 16'h8010);
    issue(2'd0, 2'd2, 4'd9);
    check("R4", "remove absent node", sharer_mask, 16'h8010);
    issue(2'd0, 2'd2, 4'd15);
    check("R4", "remove present node", sharer_mask, 16'h0010);
    // R9 removal produces no invalidation
    check("R9", "no inv on remove", {15'd0, inv_valid}, 16'h0000);

    // R1 reset in mid-operation clears the entry
    issue(2'd0, 2'd0, 4'd0);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1", "async reset sharers", sharer_mask, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    // R7 replace index restarts at slot 0 after reset
    issue(2'd1, 2'd1, 4'd1);
    issue(2'd1, 2'd1, 4'd2);
    issue(2'd1, 2'd1, 4'd3);
    issue(2'd1, 2'd1, 4'd4);
    check("R7", "victim after reset", inv_mask, 16'h0002);
    check("R7", "sharers after replace", sharer_mask, 16'h001C);
    issue(2'd0, 2'd0, 4'd0);
    finish_run();
  end
endmodule